// File: doc/BRIEF.md
# Byte-Pointer Memory Target for SMBus

This block is a set of SMBus targets, each fronting its own 256-byte memory through an 8-bit address pointer. It sits behind a transaction decoder that has already handled bit timing, START/STOP and acknowledge. Each bus event reaches the block as one strobe. The strobe carries the event kind, the 7-bit target address, a command byte, the index of the data byte within the transaction and a data byte. `NUM_INST` targets share the bus. Target `g` answers at `BASE_ADDR + g` and owns a private region.

Multi-byte writes and reads are raw byte streams with no count byte in front. A write with a command byte stores data at the command address plus the byte index, and wraps from 255 to 0. A read with a command byte loads the pointer on its first byte and then streams from the pointer. Contents are volatile and are not cleared by reset. A separate initialisation port preloads each region, normally while reset is held.

Top module: `smbus_mem_target`

## Requirements
- R1: Synchronous active-high reset clears every target's pointer to 0 and drives `rd_valid` low. Memory contents are kept through reset.
- R2: A send-byte event (kind 1) loads its data byte into the addressed target's pointer and writes no memory location.
- R3: A receive-byte event (kind 2) returns the byte at the pointer and then increments the pointer modulo 256, so 255 is followed by 0.
- R4: A command write event (kind 3) stores its data byte at address (command + byte index) modulo 256, so a stream that passes 255 continues at 0.
- R5: A command write event leaves the target's pointer unchanged.
- R6: A command read event (kind 4) with byte index 0 loads the pointer from the command byte before reading. With any other index it ignores the command byte. In both cases it returns the byte at the pointer and advances the pointer as R3 does.
- R7: A quick command (kind 0) is accepted and changes neither the pointer nor memory.
- R8: An event whose 7-bit address is outside `BASE_ADDR` to `BASE_ADDR+NUM_INST-1` is ignored by all targets. Each target's pointer and memory are independent of the others.
- R9: `rd_valid` is high, with `rd_data` holding the result, exactly in the cycle after a matching receive-byte or command read strobe, and is low otherwise.
- R10: An `init_we` strobe writes `init_data` at `init_addr` of the target selected by `init_sel`, and takes priority over a bus write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Decoded bus event strobe |
| ev_kind | input | 3 | 0 quick, 1 send byte, 2 receive byte, 3 command write, 4 command read |
| ev_tgt | input | 7 | 7-bit target address of the event |
| ev_cmd | input | AW (8) | Command byte (start address) |
| ev_idx | input | AW (8) | Index of the data byte within the transaction |
| ev_data | input | DW (8) | Data byte for send and write events |
| init_we | input | 1 | Preload write strobe |
| init_sel | input | SEL_W (1) | Target selected for preload |
| init_addr | input | AW (8) | Preload address |
| init_data | input | DW (8) | Preload data |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | DW (8) | Read result byte |

## Verification
The bench preloads both regions with distinct patterns. It then drives directed sequences. A pointer loaded to 0xFE and read three times shows whether the pointer wraps. A command write starting at 0xFD and running five bytes shows whether the store wraps. A command read with a non-zero index and an unrelated command byte shows that the pointer, not the command byte, addresses the read. Quick commands, writes and foreign addresses are placed between reads, so any pointer or memory disturbance appears in the next returned byte. A long random mix over both instances and two non-matching addresses is then compared cycle by cycle against a behavioural model.

// File: rtl/smbus_mem_pkg.sv
package smbus_mem_pkg;

    localparam int MEM_AW   = 8;
    localparam int BYTE_W   = 8;
    localparam int DEV_AW   = 7;

    typedef enum logic [2:0] {
        EV_QUICK = 3'd0,
        EV_SEND  = 3'd1,
        EV_RECV  = 3'd2,
        EV_WRITE = 3'd3,
        EV_READ  = 3'd4
    } ev_kind_e;

    typedef struct packed {
        ev_kind_e                kind;
        logic [DEV_AW-1:0]       tgt;
        logic [MEM_AW-1:0]       cmd;
        logic [MEM_AW-1:0]       idx;
        logic [BYTE_W-1:0]       data;
    } bus_ev_t;

    function automatic logic kind_reads(input ev_kind_e k);
        return (k == EV_RECV) || (k == EV_READ);
    endfunction

endpackage

// File: rtl/smbus_ptr_ctrl.sv
module smbus_ptr_ctrl
    import smbus_mem_pkg::*;
#(
    parameter int AW = MEM_AW,
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hit,
    input  ev_kind_e      kind,
    input  logic [AW-1:0] cmd,
    input  logic [AW-1:0] idx,
    input  logic [DW-1:0] data,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr
);

    logic [AW-1:0] ptr_q;

    always_comb begin
        rd_en   = hit && kind_reads(kind);
        rd_addr = ((kind == EV_READ) && (idx == '0)) ? cmd : ptr_q;
        wr_en   = hit && (kind == EV_WRITE);
        wr_addr = cmd + idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (hit) begin
            case (kind)
                EV_SEND:         ptr_q <= data[AW-1:0];
                EV_RECV, EV_READ: ptr_q <= rd_addr + AW'(1);
                default:         ptr_q <= ptr_q;
            endcase
        end
    end

    assert_send_loads_R2: assert property (@(posedge clk) disable iff (rst)
        (hit && kind == EV_SEND) |=> (ptr_q == $past(data[AW-1:0])));

    assert_recv_advances_R3: assert property (@(posedge clk) disable iff (rst)
        (hit && kind == EV_RECV) |=> (ptr_q == $past(ptr_q) + AW'(1)));

    assert_write_keeps_ptr_R5: assert property (@(posedge clk) disable iff (rst)
        (hit && kind == EV_WRITE) |=> $stable(ptr_q));

    assert_first_read_loads_R6: assert property (@(posedge clk) disable iff (rst)
        (hit && kind == EV_READ && idx == '0) |=> (ptr_q == $past(cmd) + AW'(1)));

    assert_quick_keeps_ptr_R7: assert property (@(posedge clk) disable iff (rst)
        (hit && kind == EV_QUICK) |=> $stable(ptr_q));

    assert_miss_keeps_ptr_R8: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(ptr_q));

endmodule

// File: rtl/smbus_byte_store.sv
module smbus_byte_store
    import smbus_mem_pkg::*;
#(
    parameter int AW = MEM_AW,
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          init_we,
    input  logic [AW-1:0] init_addr,
    input  logic [DW-1:0] init_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_q
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (init_we) begin
            cells[init_addr] <= init_data;
        end else if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rd_q <= cells[rd_addr];
        end
    end

endmodule

// File: rtl/smbus_tgt_slice.sv
module smbus_tgt_slice
    import smbus_mem_pkg::*;
#(
    parameter int                AW       = MEM_AW,
    parameter int                DW       = BYTE_W,
    parameter logic [DEV_AW-1:0] DEV_ADDR = 7'h50
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ev_valid,
    input  bus_ev_t       ev,
    input  logic          init_we,
    input  logic [AW-1:0] init_addr,
    input  logic [DW-1:0] init_data,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);

    logic          hit;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic          wr_en;
    logic [AW-1:0] wr_addr;

    assign hit = ev_valid && (ev.tgt == DEV_ADDR);

    smbus_ptr_ctrl #(.AW(AW), .DW(DW)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .hit     (hit),
        .kind    (ev.kind),
        .cmd     (ev.cmd[AW-1:0]),
        .idx     (ev.idx[AW-1:0]),
        .data    (ev.data[DW-1:0]),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr)
    );

    smbus_byte_store #(.AW(AW), .DW(DW)) u_store (
        .clk       (clk),
        .init_we   (init_we),
        .init_addr (init_addr),
        .init_data (init_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (ev.data[DW-1:0]),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_q      (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) rd_valid <= 1'b0;
        else     rd_valid <= rd_en;
    end

endmodule

// File: rtl/smbus_mem_target.sv
module smbus_mem_target
    import smbus_mem_pkg::*;
#(
    parameter int                NUM_INST  = 2,
    parameter logic [DEV_AW-1:0] BASE_ADDR = 7'h50,
    parameter int                AW        = MEM_AW,
    parameter int                DW        = BYTE_W,
    localparam int               SEL_W     = (NUM_INST > 1) ? $clog2(NUM_INST) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic [2:0]        ev_kind,
    input  logic [DEV_AW-1:0] ev_tgt,
    input  logic [AW-1:0]     ev_cmd,
    input  logic [AW-1:0]     ev_idx,
    input  logic [DW-1:0]     ev_data,
    input  logic              init_we,
    input  logic [SEL_W-1:0]  init_sel,
    input  logic [AW-1:0]     init_addr,
    input  logic [DW-1:0]     init_data,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data
);

    bus_ev_t       ev;
    logic [NUM_INST-1:0] slice_valid;
    logic [DW-1:0] slice_data [NUM_INST];

    always_comb begin
        ev      = '0;
        ev.kind = ev_kind_e'(ev_kind);
        ev.tgt  = ev_tgt;
        ev.cmd  = MEM_AW'(ev_cmd);
        ev.idx  = MEM_AW'(ev_idx);
        ev.data = BYTE_W'(ev_data);
    end

    for (genvar g = 0; g < NUM_INST; g++) begin : g_slice
        smbus_tgt_slice #(
            .AW       (AW),
            .DW       (DW),
            .DEV_ADDR (DEV_AW'(BASE_ADDR + DEV_AW'(g)))
        ) u_slice (
            .clk       (clk),
            .rst       (rst),
            .ev_valid  (ev_valid),
            .ev        (ev),
            .init_we   (init_we && (init_sel == SEL_W'(g))),
            .init_addr (init_addr),
            .init_data (init_data),
            .rd_valid  (slice_valid[g]),
            .rd_data   (slice_data[g])
        );
    end

    always_comb begin
        rd_valid = |slice_valid;
        rd_data  = '0;
        for (int g = 0; g < NUM_INST; g++) begin
            rd_data = rd_data | (slice_data[g] & {DW{slice_valid[g]}});
        end
    end

    localparam logic [DEV_AW:0] TGT_LO = {1'b0, BASE_ADDR};
    localparam logic [DEV_AW:0] TGT_HI = TGT_LO + (DEV_AW+1)'(NUM_INST);

    logic in_range;
    logic rd_req;
    assign in_range = ({1'b0, ev_tgt} >= TGT_LO) && ({1'b0, ev_tgt} < TGT_HI);
    assign rd_req   = ev_valid && in_range && (ev_kind == 3'd2 || ev_kind == 3'd4);

    assert_rd_latency_R9: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);

    assert_no_spurious_rd_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_valid);

    assert_single_responder_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slice_valid));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !rd_valid);

endmodule

// File: tb/test_smbus_mem_target.sv
module test_smbus_mem_target;

    localparam int CLK_PERIOD = 10;
    localparam int NI = 2;
    localparam int BASE = 'h50;

    logic       clk = 1'b0;
    logic       rst;
    logic       ev_valid;
    logic [2:0] ev_kind;
    logic [6:0] ev_tgt;
    logic [7:0] ev_cmd, ev_idx, ev_data;
    logic       init_we;
    logic [0:0] init_sel;
    logic [7:0] init_addr, init_data;
    logic       rd_valid;
    logic [7:0] rd_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    smbus_mem_target i_smbus_mem_target (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_tgt(ev_tgt), .ev_cmd(ev_cmd), .ev_idx(ev_idx), .ev_data(ev_data),
        .init_we(init_we), .init_sel(init_sel), .init_addr(init_addr),
        .init_data(init_data), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    int   n_cmp = 0;
    int   n_bad = 0;
    int   mdl_mem [NI][256];
    int   mdl_ptr [NI];
    logic exp_valid = 1'b0;
    int   exp_data  = 0;
    string exp_tag  = "R1";

    function automatic int pattern(int inst, int a);
        return (a * 7 + inst * 91 + 3) & 255;
    endfunction

    task automatic compare();
        n_cmp++;
        if (rd_valid !== exp_valid || (exp_valid && rd_data !== 8'(exp_data))) begin
            n_bad++;
            $display("FAIL %s: rd_valid/rd_data got %0b/%02h expected %0b/%02h",
                     exp_tag, rd_valid, rd_data, exp_valid, 8'(exp_data));
        end
    endtask

    // Compare last cycle's result, then drive one event and advance the model.
    task automatic step(input logic v, input int kind, input int tgt,
                        input int cmd, input int idx, input int data, input string tag);
        int inst;
        @(negedge clk);
        compare();
        ev_valid = v;
        ev_kind  = 3'(kind);
        ev_tgt   = 7'(tgt);
        ev_cmd   = 8'(cmd);
        ev_idx   = 8'(idx);
        ev_data  = 8'(data);
        exp_tag  = tag;
        exp_valid = 1'b0;
        inst = tgt - BASE;
        if (v && inst >= 0 && inst < NI) begin
            case (kind)
                1: mdl_ptr[inst] = data & 255;
                2, 4: begin
                    if (kind == 4 && idx == 0) mdl_ptr[inst] = cmd & 255;
                    exp_valid = 1'b1;
                    exp_data  = mdl_mem[inst][mdl_ptr[inst]];
                    mdl_ptr[inst] = (mdl_ptr[inst] + 1) & 255;
                end
                3: mdl_mem[inst][(cmd + idx) & 255] = data & 255;
                default: ;
            endcase
        end
    endtask

    task automatic idle(input string tag);
        step(1'b0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL R9: watchdog expired, got no finish expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; ev_valid = 1'b0; ev_kind = '0; ev_tgt = '0;
        ev_cmd = '0; ev_idx = '0; ev_data = '0;
        init_we = 1'b0; init_sel = '0; init_addr = '0; init_data = '0;
        for (int i = 0; i < NI; i++) mdl_ptr[i] = 0;

        // R10: preload both regions while reset is held; R1: no output in reset
        for (int i = 0; i < NI; i++) begin
            for (int a = 0; a < 256; a++) begin
                @(negedge clk);
                compare();
                init_we   = 1'b1;
                init_sel  = 1'(i);
                init_addr = 8'(a);
                init_data = 8'(pattern(i, a));
                mdl_mem[i][a] = pattern(i, a);
            end
        end
        @(negedge clk);
        compare();
        init_we = 1'b0;
        rst = 1'b0;

        // R1: pointer starts at 0; R10: preloaded content visible
        step(1'b1, 2, BASE, 0, 0, 0, "R1");
        step(1'b1, 2, BASE, 0, 0, 0, "R3");
        idle("R9");
        // R10: init takes priority over a same-cycle bus write
        @(negedge clk);
        compare();
        ev_valid = 1'b1; ev_kind = 3'd3; ev_tgt = 7'(BASE);
        ev_cmd = 8'h40; ev_idx = 8'h0; ev_data = 8'h11;
        init_we = 1'b1; init_sel = 1'b0; init_addr = 8'h40; init_data = 8'h99;
        mdl_mem[0][8'h40] = 8'h99;
        exp_valid = 1'b0; exp_tag = "R10";
        @(negedge clk);
        compare();
        init_we = 1'b0; ev_valid = 1'b0;
        step(1'b1, 4, BASE, 8'h40, 0, 0, "R10");

        // R2, R3: send loads pointer, reads wrap 0xFF -> 0x00
        step(1'b1, 1, BASE, 0, 0, 8'hFE, "R2");
        step(1'b1, 2, BASE, 0, 0, 0, "R2");
        step(1'b1, 2, BASE, 0, 0, 0, "R3");
        step(1'b1, 2, BASE, 0, 0, 0, "R3");
        // R2: send writes no memory
        step(1'b1, 1, BASE, 0, 0, 8'h20, "R2");
        step(1'b1, 2, BASE, 0, 0, 0, "R2");

        // R4: write stream wraps past 255; R5: pointer untouched
        for (int k = 0; k < 5; k++) step(1'b1, 3, BASE, 8'hFD, k, 8'hA0 + k, "R4");
        step(1'b1, 2, BASE, 0, 0, 0, "R5");
        // R6: command read loads pointer on first byte only
        for (int k = 0; k < 5; k++) step(1'b1, 4, BASE, 8'hFD, k, 0, "R6");
        step(1'b1, 4, BASE, 8'h80, 3, 0, "R6");

        // R7: quick command has no effect
        step(1'b1, 0, BASE, 8'h10, 0, 8'h33, "R7");
        step(1'b1, 2, BASE, 0, 0, 0, "R7");

        // R8: foreign addresses ignored
        step(1'b1, 2, BASE - 1, 0, 0, 0, "R8");
        step(1'b1, 4, BASE + NI, 8'h00, 0, 0, "R8");
        step(1'b1, 1, BASE + NI, 0, 0, 8'h00, "R8");
        step(1'b1, 3, BASE - 1, 8'h04, 0, 8'h55, "R8");
        step(1'b1, 2, BASE, 0, 0, 0, "R8");
        // R8: second instance independent
        step(1'b1, 2, BASE + 1, 0, 0, 0, "R8");
        step(1'b1, 3, BASE + 1, 8'h04, 0, 8'h5A, "R8");
        step(1'b1, 4, BASE + 1, 8'h04, 0, 0, "R8");
        step(1'b1, 4, BASE, 8'h04, 0, 0, "R8");
        // R9: back-to-back then idle
        step(1'b1, 2, BASE, 0, 0, 0, "R9");
        step(1'b1, 2, BASE + 1, 0, 0, 0, "R9");
        idle("R9");
        idle("R9");

        // Mixed random traffic (R3, R4, R6, R8)
        for (int n = 0; n < 600; n++) begin
            int k, t;
            k = int'($urandom_range(0, 4));
            t = BASE - 1 + int'($urandom_range(0, NI + 1));
            step(1'(($urandom_range(0, 7)) != 0), k, t,
                 int'($urandom_range(0, 255)), int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 255)), "R6");
        end
        idle("R9");
        idle("R9");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule